// File: doc/BRIEF.md
# Reference-Switch Phase-Offset Compensator

When a digital PLL moves from one input reference to another, the two references can be at any phase to each other. If the loop locked straight onto the new edge, the output clock would step in phase and data could be lost. This block prevents that step. On a start request from the PLL state machine it waits for the next rising edge of the new, skew-adjusted reference. It then counts fast sampling-clock cycles until the next rising edge of the loop feedback, keeps that count and signals completion.

Once the measurement is complete, the block works as a fixed delay line. Every rising edge of the incoming reference is held back by the stored count, and a one-cycle virtual reference pulse comes out. The phase detector compares this virtual reference with the feedback. Because the gap it sees is the gap that existed before the switch, the output phase does not move.

Both pulse inputs pass through a flip-flop synchronizer and then a rising-edge detector. The start request comes from logic in the same clock domain and is used as it arrives. The asynchronous active-low reset is released synchronously inside the block.

Top module: `refsw_phase_comp`

## Requirements
- R1: While reset is asserted, and after it is released, `done` and `vref` are low. The stored measurement is cleared to 0.
- R2: `ref_in` and `fb_in` pass through two synchronizing flip-flops and a rising-edge detector. A level change set up before clock edge k is acted on at edge k+2, and each rising edge is acted on exactly once.
- R3: A `start` pulse sampled while idle arms a measurement. The next detected reference rise begins counting, and the next detected feedback rise ends it. The stored value is the number of clock edges between those two detections. If both are detected at the same edge, the value is 0. A feedback rise with no measurement in progress has no effect.
- R4: The measured count saturates at 2^CNT_W-1 and does not wrap.
- R5: `done` is high for exactly one cycle, the cycle after the edge that detects the terminating feedback rise. With `fb_in` rising ahead of edge k, `done` is high between edges k+2 and k+3.
- R6: A `start` pulse sampled while a measurement is armed or counting is ignored. The count continues and the result is unaffected.
- R7: When no measurement is pending, a reference rise set up before edge k produces one `vref` pulse, one cycle wide, between edges k+2+D and k+3+D, where D is the stored value.
- R8: A reference rise detected while a delay is counting is queued. It is reloaded with D at the edge that ends the current pulse, so its pulse follows D+1 cycles after the earlier one. A further rise detected while an entry is already queued is dropped.
- R9: From the edge that accepts `start` until the measurement completes, `vref` stays low. Any delay in flight or queued is discarded, and reference rises produce no pulse.
- R10: Asserting reset after a measurement returns the stored value to 0, so the next reference rise is passed with the zero-delay timing of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Measurement request from the PLL state machine (same clock domain) |
| ref_in | input | 1 | New reference pulse after skew adjustment (asynchronous) |
| fb_in | input | 1 | Loop feedback pulse (asynchronous) |
| done | output | 1 | One-cycle pulse when a measurement completes |
| vref | output | 1 | Virtual reference pulse, the reference edge delayed by the stored gap |

## Verification
The bench builds the block with CNT_W = 5, so the count saturates at 31. A sweep of every phase gap from 0 to 33 cycles then covers the coincident-edge case, every value in range and the saturation limit. Each swept value is checked twice: once against the timing of `done`, and once against the delay replayed on a later reference edge. Directed sequences cover a second start during counting, the queue with a dropped third edge, the flush of an in-flight delay when a new measurement begins, and the clearing of the stored value by reset.

// File: rtl/refsw_pkg.sv
package refsw_pkg;

  typedef enum logic [1:0] {
    MS_IDLE  = 2'd0,
    MS_ARMED = 2'd1,
    MS_COUNT = 2'd2
  } meter_state_e;

endpackage

// File: rtl/refsw_rst_sync.sv
module refsw_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_n_o = stage_q[1];

endmodule

// File: rtl/refsw_edge_sync.sv
module refsw_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);

  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;
  logic              prev_q;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
      prev_q <= 1'b0;
    end else begin
      pipe_q <= pipe_d;
      prev_q <= pipe_q[STAGES-1];
    end
  end

  assign rise = pipe_q[STAGES-1] & ~prev_q;

  // A detected rise lasts exactly one cycle (R2)
  assert_single_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/refsw_phase_meter.sv
module refsw_phase_meter
  import refsw_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             ref_rise,
  input  logic             fb_rise,
  output logic             idle,
  output logic [CNT_W-1:0] measured,
  output logic             done
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  meter_state_e     state_q, state_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic [CNT_W-1:0] meas_q, meas_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] count_inc;
  logic             count_en, meas_en;

  assign count_inc = (count_q == CNT_MAX) ? CNT_MAX : count_q + 1'b1;

  always_comb begin
    state_d  = state_q;
    count_d  = count_q;
    meas_d   = meas_q;
    done_d   = 1'b0;
    count_en = 1'b0;
    meas_en  = 1'b0;
    case (state_q)
      MS_IDLE: begin
        if (start) begin
          state_d = MS_ARMED;
        end
      end
      MS_ARMED: begin
        if (ref_rise) begin
          if (fb_rise) begin
            meas_d  = '0;
            meas_en = 1'b1;
            done_d  = 1'b1;
            state_d = MS_IDLE;
          end else begin
            count_d  = '0;
            count_en = 1'b1;
            state_d  = MS_COUNT;
          end
        end
      end
      MS_COUNT: begin
        if (fb_rise) begin
          meas_d  = count_inc;
          meas_en = 1'b1;
          done_d  = 1'b1;
          state_d = MS_IDLE;
        end else begin
          count_d  = count_inc;
          count_en = 1'b1;
        end
      end
      default: begin
        state_d = MS_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MS_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (count_en) begin
      count_q <= count_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meas_q <= '0;
    end else if (meas_en) begin
      meas_q <= meas_d;
    end
  end

  assign idle     = (state_q == MS_IDLE);
  assign measured = meas_q;
  assign done     = done_q;

  // A start while idle arms the measurement (R3)
  assert_arm_on_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MS_IDLE && start) |=> (state_q == MS_ARMED));

  // The count holds at its ceiling instead of wrapping (R4)
  assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MS_COUNT && count_q == CNT_MAX && !fb_rise) |=> (count_q == CNT_MAX));

  // Done follows a detected feedback rise and lasts one cycle (R5)
  assert_done_after_fb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(fb_rise));
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // A start during counting does not restart or abort the count (R6)
  assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MS_COUNT && start && !fb_rise) |=> (state_q == MS_COUNT && count_q != '0));

endmodule

// File: rtl/refsw_edge_delay.sv
module refsw_edge_delay #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             ref_rise,
  input  logic [CNT_W-1:0] load_val,
  output logic             vref
);

  logic             busy_q, busy_d;
  logic             queued_q, queued_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             fire;

  assign fire = busy_q && (cnt_q == '0);

  always_comb begin
    busy_d   = busy_q;
    queued_d = queued_q;
    cnt_d    = cnt_q;
    cnt_en   = 1'b0;
    if (!en) begin
      busy_d   = 1'b0;
      queued_d = 1'b0;
    end else if (fire) begin
      if (queued_q || ref_rise) begin
        busy_d   = 1'b1;
        cnt_d    = load_val;
        cnt_en   = 1'b1;
        queued_d = 1'b0;
      end else begin
        busy_d = 1'b0;
      end
    end else if (busy_q) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
      if (ref_rise) begin
        queued_d = 1'b1;
      end
    end else if (ref_rise) begin
      busy_d = 1'b1;
      cnt_d  = load_val;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      queued_q <= 1'b0;
    end else begin
      busy_q   <= busy_d;
      queued_q <= queued_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign vref = fire && en;

  // With a non-zero delay each replayed edge gives a one-cycle pulse (R7)
  assert_vref_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vref && load_val != '0) |=> !vref);

  // A rise during a running delay is held in the queue (R8)
  assert_queue_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && busy_q && !fire && ref_rise) |=> queued_q);

  // Leaving delay mode discards the running and queued edges (R9)
  assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!busy_q && !queued_q));

endmodule

// File: rtl/refsw_phase_comp.sv
module refsw_phase_comp #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ref_in,
  input  logic fb_in,
  output logic done,
  output logic vref
);

  localparam int NUM_IN  = 2;
  localparam int IDX_REF = 0;
  localparam int IDX_FB  = 1;

  logic              rst_sync_n;
  logic [NUM_IN-1:0] raw_in;
  logic [NUM_IN-1:0] rise_vec;
  logic              meter_idle;
  logic [CNT_W-1:0]  stored_gap;

  refsw_rst_sync i_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  assign raw_in[IDX_REF] = ref_in;
  assign raw_in[IDX_FB]  = fb_in;

  for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_sync
    refsw_edge_sync #(
      .STAGES (SYNC_STAGES)
    ) i_sync (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .din   (raw_in[gi]),
      .rise  (rise_vec[gi])
    );
  end

  refsw_phase_meter #(
    .CNT_W (CNT_W)
  ) i_meter (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (start),
    .ref_rise (rise_vec[IDX_REF]),
    .fb_rise  (rise_vec[IDX_FB]),
    .idle     (meter_idle),
    .measured (stored_gap),
    .done     (done)
  );

  refsw_edge_delay #(
    .CNT_W (CNT_W)
  ) i_delay (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .en       (meter_idle),
    .ref_rise (rise_vec[IDX_REF]),
    .load_val (stored_gap),
    .vref     (vref)
  );

  // Outputs stay quiet while the synchronized reset is active (R1)
  always_comb begin
    if (!rst_sync_n) begin
      assert_quiet_in_reset_R1: assert (!done && !vref);
    end
  end

  // No virtual reference while a measurement is armed or running (R9)
  assert_no_vref_measuring_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !meter_idle |-> !vref);

endmodule

// File: tb/test_refsw_phase_comp.sv
`timescale 1ns/1ps
module test_refsw_phase_comp;

  localparam int W   = 5;
  localparam int SAT = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n, start, ref_in, fb_in;
  wire  done, vref;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  int vq[$];
  int dq[$];

  refsw_phase_comp #(.CNT_W(W), .SYNC_STAGES(2)) i_refsw_phase_comp (
    .clk(clk), .rst_n(rst_n), .start(start), .ref_in(ref_in),
    .fb_in(fb_in), .done(done), .vref(vref)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (vref) vq.push_back(cyc);
    if (done) dq.push_back(cyc);
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_hits(string req, string what, input int q[$], int n, int e0, int e1);
    chk(req, {what, " count"}, q.size(), n);
    if (n > 0 && q.size() > 0) chk(req, {what, " first cycle"}, q[0], e0);
    if (n > 1 && q.size() > 1) chk(req, {what, " second cycle"}, q[1], e1);
  endtask

  task automatic ticks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_q();
    vq.delete();
    dq.delete();
  endtask

  task automatic pulse_ref(int dly);
    repeat (dly) @(negedge clk);
    ref_in = 1'b1;
    repeat (2) @(negedge clk);
    ref_in = 1'b0;
  endtask

  task automatic pulse_fb(int dly);
    repeat (dly) @(negedge clk);
    fb_in = 1'b1;
    repeat (2) @(negedge clk);
    fb_in = 1'b0;
  endtask

  task automatic do_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // start, then reference at c, feedback at c+d
  task automatic measure(int d, output int c);
    do_start();
    @(negedge clk);
    c = cyc;
    fork
      pulse_ref(0);
      pulse_fb(d);
    join
    ticks(8);
  endtask

  // one reference edge in delay mode, expected after stored gap g
  task automatic replay(string req, int g);
    int c2;
    clear_q();
    c2 = cyc;
    pulse_ref(0);
    ticks(SAT + 8);
    chk_hits(req, "vref", vq, 1, c2 + 3 + g, 0);
  endtask

  always @(posedge clk) begin
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int c;
    rst_n = 1'b0; start = 1'b0; ref_in = 1'b0; fb_in = 1'b0;
    ticks(3);
    chk("R1", "done in reset", done, 0);
    chk("R1", "vref in reset", vref, 0);
    rst_n = 1'b1;
    ticks(4);
    chk("R1", "done after reset", done, 0);
    chk("R1", "vref after reset", vref, 0);

    // R1 R2 R7: stored value is 0 after reset, three-edge path latency
    replay("R1", 0);

    // R3: feedback without a measurement does nothing
    clear_q();
    pulse_fb(0);
    ticks(10);
    chk("R3", "done without start", dq.size(), 0);

    // R3 R4 R5 R7: sweep every gap up to and past saturation
    for (int d = 0; d <= SAT + 2; d++) begin
      int g;
      g = (d > SAT) ? SAT : d;
      clear_q();
      measure(d, c);
      chk_hits("R5", "done", dq, 1, c + d + 3, 0);
      chk("R9", "vref while measuring", vq.size(), 0);
      replay((d > SAT) ? "R4" : "R7", g);
    end

    // R6: second start during counting is ignored
    clear_q();
    do_start();
    @(negedge clk);
    c = cyc;
    fork
      pulse_ref(0);
      pulse_fb(20);
      begin ticks(8); do_start(); end
    join
    ticks(8);
    chk_hits("R6", "done", dq, 1, c + 23, 0);
    replay("R6", 20);

    // R8: queue one edge, drop the third (stored gap 10)
    measure(10, c);
    clear_q();
    c = cyc;
    fork
      pulse_ref(0);
      pulse_ref(4);
      pulse_ref(8);
    join
    ticks(30);
    chk_hits("R8", "vref", vq, 2, c + 13, c + 24);

    // R9: start flushes a running delay, no pulses until done
    clear_q();
    c = cyc;
    fork
      pulse_ref(0);
      begin ticks(5); do_start(); end
      begin ticks(8); pulse_ref(0); end
      begin ticks(14); pulse_ref(0); end
      begin ticks(23); pulse_fb(0); end
    join
    ticks(20);
    chk("R9", "vref count", vq.size(), 0);
    chk_hits("R9", "done", dq, 1, c + 26, 0);
    replay("R9", 15);

    // R10: reset clears the stored gap
    rst_n = 1'b0;
    ticks(2);
    chk("R10", "vref in reset", vref, 0);
    chk("R10", "done in reset", done, 0);
    rst_n = 1'b1;
    ticks(4);
    replay("R10", 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule